// File: doc/BRIEF.md
# Variable-Length Corrected Block TEA Round Datapath

This block runs the rounds of the corrected block TEA cipher over a message of two up to `MAX_WORDS` 32-bit words. The words sit in a ring register that rotates one slot to the left on every clock. Each clock performs one partial round. The mixing function is evaluated on the word at the head of the ring, using the word behind it and the word written in the previous step. Its result is added to the head word when encrypting and subtracted from it when decrypting. The updated word is written into the tail slot of the active length. After `n` partial rounds one full round is complete and the ring is back in its starting order. The same ring serves both directions. On load, a decrypt message is stored in reverse word order, and two mode-controlled multiplexers swap the two mixing operands.

A separate key scheduler sits next to this block and supplies the round sum and the selected subkey. The datapath presents the partial-round index so that the scheduler can pick the subkey. It also raises a strobe in the last partial round of every round, which tells the scheduler to step its sum. The number of rounds is `6 + floor(52/n)`. When the last round finishes, the block pulses `done` and holds the result until the next start.

Control is a three-state machine:
- `ST_IDLE` goes to `ST_RUN` when `start` is high. The message, the mode and the clamped word count are loaded at that edge.
- `ST_RUN` steps one partial round per clock. It goes to `ST_DONE` after the last partial round of the last round.
- `ST_DONE` drives `done` for one cycle and then returns to `ST_IDLE`.

Top module: `xxtea_round_path`

## Requirements
- R1: When encrypting, `state_out` after `done` equals the software result of the corrected block TEA encryption of the `n` loaded words. This holds for any `n`, with the sum and subkey supplied by the scheduler. Word i is at bits [32i+31:32i].
- R2: When decrypting, the block reverses R1: decrypting an encryption result returns the original words.
- R3: With all four key words set to ffffffff, encrypting the words a8137c15, 575eba50, 91776d30 (n=3) gives ef1c60b2, 72b778b0, 6abaccab. Decrypting those gives the plaintext back.
- R4: `done` is high for exactly one cycle, n·q+1 clock cycles after the edge that accepts `start`, where q = 6 + floor(52/n).
- R5: During the run, `sub_idx` changes once per clock. It counts 0,1,…,n-1 when encrypting and n-1,…,1,0 when decrypting, repeating every round.
- R6: `round_done` is high exactly in the last partial round of each round, and at no other time.
- R7: Words at index n and above of `state_out` read zero. The result stays on `state_out` after `done` until the next start.
- R8: A `start` received while a run is in progress is ignored. The result, the timing and the index sequence of the current run are unchanged.
- R9: A word count below 2 is treated as 2, and one above `MAX_WORDS` is treated as `MAX_WORDS`.
- R10: After reset, `done` and `round_done` are low and `state_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt; latched at start |
| word_cnt | input | $clog2(MAX_WORDS+1) | Number of valid 32-bit words; latched at start |
| state_in | input | 32·MAX_WORDS | Message words, word i at bits [32i+31:32i] |
| sum_in | input | 32 | Round sum from the scheduler |
| subkey | input | 32 | Subkey selected by the scheduler for the current index |
| sub_idx | output | $clog2(MAX_WORDS) | Partial-round index presented to the scheduler |
| round_done | output | 1 | Strobe in the last partial round of each round |
| done | output | 1 | One-cycle pulse when the result is ready |
| state_out | output | 32·MAX_WORDS | Result words, same layout as `state_in` |

## Verification
The bench builds the block with the default `MAX_WORDS` of 8 and a 4-bit word count. This reaches the shortest message (2 words, 32 rounds), an odd length (3 words, with the known-answer vector), a middle length (5 words) and the full 8-word ring. The word-count field can also carry values below 2 and above 8, so both clamp directions are exercised. A behavioural scheduler and a software model of the cipher predict the index, the strobe and the done pulse on every clock, and the final words of each run.

// File: rtl/xxr_pkg.sv
package xxr_pkg;
    localparam int WORD_W      = 32;
    localparam int BASE_ROUNDS = 6;
    localparam int ROUND_NUM   = 52;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/xxr_mix.sv
module xxr_mix
    import xxr_pkg::*;
(
    input  word_t y_w,
    input  word_t z_w,
    input  word_t sum_w,
    input  word_t key_w,
    output word_t mix_w
);
    word_t shift_part;
    word_t key_part;

    always_comb begin
        shift_part = ((z_w >> 5) ^ (y_w << 2)) + ((y_w >> 3) ^ (z_w << 4));
        key_part   = (sum_w ^ y_w) + (key_w ^ z_w);
        mix_w      = shift_part ^ key_part;
    end
endmodule

// File: rtl/xxr_ring.sv
module xxr_ring
    import xxr_pkg::*;
#(
    parameter  int MAX_WORDS = 8,
    localparam int CW = $clog2(MAX_WORDS + 1),
    localparam int PW = $clog2(MAX_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  word_t [MAX_WORDS-1:0]   load_w,
    input  logic                    step,
    input  logic [CW-1:0]           n_act,
    input  word_t                   new_word,
    output word_t [MAX_WORDS-1:0]   words_o
);
    logic [PW-1:0] tail_ix;
    assign tail_ix = PW'(n_act - CW'(1));

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        word_t follow;
        if (g < MAX_WORDS - 1) begin : g_inner
            assign follow = words_o[g+1];
        end else begin : g_last
            assign follow = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_o[g] <= '0;
            end else if (load) begin
                words_o[g] <= load_w[g];
            end else if (step) begin
                if (g == int'(n_act) - 1)
                    words_o[g] <= new_word;
                else if (g < int'(n_act) - 1)
                    words_o[g] <= follow;
            end
        end
    end

    // R1
    tail_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> words_o[tail_ix] == $past(new_word));
endmodule

// File: rtl/xxr_ctrl.sv
module xxr_ctrl
    import xxr_pkg::*;
#(
    parameter  int MAX_WORDS = 8,
    localparam int CW = $clog2(MAX_WORDS + 1),
    localparam int PW = $clog2(MAX_WORDS),
    localparam int MAX_Q = BASE_ROUNDS + ROUND_NUM / 2,
    localparam int RW = $clog2(MAX_Q + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dec_in,
    input  logic [CW-1:0] n_in,
    output logic          load,
    output logic          step,
    output logic          dec_act,
    output logic [CW-1:0] n_act,
    output logic [PW-1:0] sub_idx,
    output logic          round_done,
    output logic          done
);
    ctl_state_t    state, nxt;
    logic [PW-1:0] cnt;
    logic [RW-1:0] rnd, q_act;
    logic          last_sub, last_rnd;

    function automatic logic [RW-1:0] rounds_of(input logic [CW-1:0] n);
        return RW'(BASE_ROUNDS + ROUND_NUM / int'(n));
    endfunction

    assign last_sub = int'(cnt) == int'(n_act) - 1;
    assign last_rnd = int'(rnd) == int'(q_act) - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_RUN;
            ST_RUN:  if (last_sub && last_rnd) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_act   <= CW'(2);
            dec_act <= 1'b0;
            q_act   <= RW'(MAX_Q);
            cnt     <= '0;
            rnd     <= '0;
        end else if (load) begin
            n_act   <= n_in;
            dec_act <= dec_in;
            q_act   <= rounds_of(n_in);
            cnt     <= '0;
            rnd     <= '0;
        end else if (step) begin
            if (last_sub) begin
                cnt <= '0;
                rnd <= rnd + RW'(1);
            end else begin
                cnt <= cnt + PW'(1);
            end
        end
    end

    always_comb begin
        load       = (state == ST_IDLE) && start;
        step       = (state == ST_RUN);
        round_done = step && last_sub;
        done       = (state == ST_DONE);
        sub_idx    = dec_act ? PW'(int'(n_act) - 1 - int'(cnt)) : cnt;
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    strobe_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(round_done));

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> int'(sub_idx) < int'(n_act));

    // R5
    idx_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !round_done) |=>
            sub_idx == (dec_act ? $past(sub_idx) - PW'(1) : $past(sub_idx) + PW'(1)));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start) |=> ($stable(n_act) && $stable(dec_act) && $stable(q_act)));

    // R9
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (int'(n_act) >= 2 && int'(n_act) <= MAX_WORDS));
endmodule

// File: rtl/xxtea_round_path.sv
module xxtea_round_path
    import xxr_pkg::*;
#(
    parameter  int MAX_WORDS = 8,
    localparam int CW = $clog2(MAX_WORDS + 1),
    localparam int PW = $clog2(MAX_WORDS),
    localparam int DW = MAX_WORDS * WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          decrypt,
    input  logic [CW-1:0] word_cnt,
    input  logic [DW-1:0] state_in,
    input  logic [31:0]   sum_in,
    input  logic [31:0]   subkey,
    output logic [PW-1:0] sub_idx,
    output logic          round_done,
    output logic          done,
    output logic [DW-1:0] state_out
);
    word_t [MAX_WORDS-1:0] in_w, load_w, ring_w, out_w;
    logic [CW-1:0]         n_clamp, n_act;
    logic [PW-1:0]         tail_ix;
    logic                  load, step, dec_act;
    word_t                 y_sel, z_sel, mix_val, new_word;

    assign in_w = state_in;

    always_comb begin
        if (word_cnt < CW'(2))
            n_clamp = CW'(2);
        else if (word_cnt > CW'(MAX_WORDS))
            n_clamp = CW'(MAX_WORDS);
        else
            n_clamp = word_cnt;
    end

    always_comb begin
        for (int i = 0; i < MAX_WORDS; i++) begin
            load_w[i] = '0;
            if (i < int'(n_clamp))
                load_w[i] = decrypt ? in_w[PW'(int'(n_clamp) - 1 - i)] : in_w[i];
        end
    end

    xxr_ctrl #(.MAX_WORDS(MAX_WORDS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dec_in(decrypt),
        .n_in(n_clamp), .load(load), .step(step), .dec_act(dec_act),
        .n_act(n_act), .sub_idx(sub_idx), .round_done(round_done), .done(done)
    );

    xxr_ring #(.MAX_WORDS(MAX_WORDS)) ring_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_w(load_w), .step(step),
        .n_act(n_act), .new_word(new_word), .words_o(ring_w)
    );

    assign tail_ix = PW'(n_act - CW'(1));
    assign y_sel   = dec_act ? ring_w[tail_ix] : ring_w[1];
    assign z_sel   = dec_act ? ring_w[1] : ring_w[tail_ix];

    xxr_mix mix_i (
        .y_w(y_sel), .z_w(z_sel), .sum_w(sum_in), .key_w(subkey), .mix_w(mix_val)
    );

    assign new_word = dec_act ? ring_w[0] - mix_val : ring_w[0] + mix_val;

    always_comb begin
        for (int i = 0; i < MAX_WORDS; i++) begin
            out_w[i] = '0;
            if (i < int'(n_act))
                out_w[i] = dec_act ? ring_w[PW'(int'(n_act) - 1 - i)] : ring_w[i];
        end
    end

    assign state_out = out_w;

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(n_act) == MAX_WORDS || out_w[MAX_WORDS-1] == '0));
endmodule

// File: tb/xxtea_round_path_tb_top.sv
module xxtea_round_path_tb_top;
    localparam int MAXW = 8;
    localparam int CW   = 4;
    localparam int PW   = 3;
    localparam int DW   = 32 * MAXW;
    localparam logic [31:0] DELTA = 32'h9e3779b9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          decrypt = 1'b0;
    logic [CW-1:0] word_cnt = '0;
    logic [DW-1:0] state_in = '0;
    logic [31:0]   sum_r = '0;
    logic [31:0]   subkey;
    logic [PW-1:0] sub_idx;
    logic          round_done, done;
    logic [DW-1:0] state_out;

    logic [31:0] key [4];
    logic [31:0] rv [8];
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    xxtea_round_path #(.MAX_WORDS(MAXW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .word_cnt(word_cnt), .state_in(state_in), .sum_in(sum_r),
        .subkey(subkey), .sub_idx(sub_idx), .round_done(round_done),
        .done(done), .state_out(state_out)
    );

    // behavioural scheduler
    assign subkey = key[sub_idx[1:0] ^ sum_r[3:2]];
    always @(posedge clk) if (round_done) sum_r <= decrypt_run ? sum_r - DELTA : sum_r + DELTA;
    logic decrypt_run = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mxf(logic [31:0] y, logic [31:0] z,
                                        logic [31:0] s, logic [31:0] k);
        return (((z >> 5) ^ (y << 2)) + ((y >> 3) ^ (z << 4))) ^ ((s ^ y) + (k ^ z));
    endfunction

    task automatic ref_run(input bit dec, input int n);
        int q = 6 + 52 / n;
        logic [31:0] y, z, s;
        int e;
        if (!dec) begin
            s = 0; z = rv[n-1];
            for (int r = 0; r < q; r++) begin
                s = s + DELTA; e = int'((s >> 2) & 3);
                for (int p = 0; p < n; p++) begin
                    y = rv[(p + 1) % n];
                    rv[p] = rv[p] + mxf(y, z, s, key[(p & 3) ^ e]);
                    z = rv[p];
                end
            end
        end else begin
            s = 32'(q) * DELTA; y = rv[0];
            for (int r = 0; r < q; r++) begin
                e = int'((s >> 2) & 3);
                for (int p = n - 1; p >= 0; p--) begin
                    z = rv[(p + n - 1) % n];
                    rv[p] = rv[p] - mxf(y, z, s, key[(p & 3) ^ e]);
                    y = rv[p];
                end
                s = s - DELTA;
            end
        end
    endtask

    task automatic run_case(input bit dec, input int n_req, input logic [31:0] din [8],
                            input bit poke, input string rq, output logic [DW-1:0] res);
        int n = (n_req < 2) ? 2 : (n_req > MAXW) ? MAXW : n_req;
        int q = 6 + 52 / n;
        logic [DW-1:0] expv = '0;
        int ep;
        for (int i = 0; i < 8; i++) rv[i] = din[i];
        ref_run(dec, n);
        for (int i = 0; i < n; i++) expv[32*i +: 32] = rv[i];
        @(negedge clk);
        decrypt = dec; decrypt_run = dec; word_cnt = CW'(n_req);
        for (int i = 0; i < MAXW; i++) state_in[32*i +: 32] = din[i];
        sum_r = dec ? 32'(q) * DELTA : DELTA;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n * q; k++) begin
            ep = dec ? n - 1 - (k % n) : k % n;
            chk(sub_idx == PW'(ep), poke ? "R8" : "R5", "sub_idx", DW'(sub_idx), DW'(ep));
            chk(round_done == ((k % n) == n - 1), "R6", "round_done", DW'(round_done),
                DW'((k % n) == n - 1));
            chk(done == 1'b0, "R4", "done early", DW'(done), '0);
            if (poke && k == 5) begin
                start = 1'b1; decrypt = ~dec; word_cnt = CW'(8); state_in = '1;
            end
            if (poke && k == 6) start = 1'b0;
            @(negedge clk);
        end
        chk(done == 1'b1, "R4", "done at n*q+1", DW'(done), DW'(1));
        chk(state_out == expv, rq, "result", state_out, expv);
        res = state_out;
        @(negedge clk);
        chk(done == 1'b0, "R4", "done width", DW'(done), '0);
        chk(state_out == expv, "R7", "result held", state_out, expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w [8];
        logic [31:0] orig [8];
        logic [31:0] seed;
        logic [DW-1:0] res, kat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(done == 1'b0, "R10", "done", DW'(done), '0);
        chk(round_done == 1'b0, "R10", "round_done", DW'(round_done), '0);
        chk(state_out == '0, "R10", "state_out", state_out, '0);

        // R1 / R3 known answer, encrypt
        for (int i = 0; i < 4; i++) key[i] = 32'hffffffff;
        w = '{32'ha8137c15, 32'h575eba50, 32'h91776d30, 0, 0, 0, 0, 0};
        run_case(1'b0, 3, w, 1'b0, "R1", res);
        kat = '0; kat[95:0] = {32'h6abaccab, 32'h72b778b0, 32'hef1c60b2};
        chk(res == kat, "R3", "encrypt vector", res, kat);

        // R2 / R3 known answer, decrypt
        w = '{32'hef1c60b2, 32'h72b778b0, 32'h6abaccab, 0, 0, 0, 0, 0};
        run_case(1'b1, 3, w, 1'b0, "R2", res);
        kat = '0; kat[95:0] = {32'h91776d30, 32'h575eba50, 32'ha8137c15};
        chk(res == kat, "R3", "decrypt vector", res, kat);

        key = '{32'h08040201, 32'h80402010, 32'hf8fcfeff, 32'h80c0e0f0};
        seed = 32'h1234abcd;
        for (int i = 0; i < 8; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223; w[i] = seed;
        end
        orig = w;

        // R1 shortest length
        run_case(1'b0, 2, w, 1'b0, "R1", res);

        // R8 full length with start poked mid-run, then R2 round trip
        run_case(1'b0, 8, w, 1'b1, "R1", res);
        for (int i = 0; i < 8; i++) w[i] = res[32*i +: 32];
        run_case(1'b1, 8, w, 1'b0, "R2", res);
        for (int i = 0; i < 8; i++)
            chk(res[32*i +: 32] == orig[i], "R2", "round trip word",
                DW'(res[32*i +: 32]), DW'(orig[i]));

        // R8 decrypt with poke, five words
        run_case(1'b1, 5, orig, 1'b1, "R2", res);

        // R9 clamp low (upper words must read zero, R7) and high
        run_case(1'b0, 1, orig, 1'b0, "R9", res);
        run_case(1'b1, 13, orig, 1'b0, "R9", res);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule